// File: doc/BRIEF.md
# PLL Clock Control Register

An 8-bit control register that sets up a PLL frequency multiplier and picks the system clock source. A CPU writes it through a one-cycle write strobe and reads it back at any time. The register drives the multiplier enable, the multiplication ratio code, the choice between the crystal clock and the PLL clock (this choice feeds an external glitch-safe clock mux), and two peripheral clock select bits.

The register applies its interlocks itself, so software cannot reach an unsafe setting. The ratio field can change only once after reset. Any change of the ratio also drops the system clock back to the crystal. The clock select cannot be set while the multiplier is disabled. A halt input marks stop mode or parallel flash programming mode. While it is high, the multiplier is off and the system runs from the crystal, and the stored bits are left untouched.

The analog PLL, the mux cell and the settling delay that software waits before it selects the PLL are outside this block.

Top module: `pll_clk_ctrl`

## Requirements
- R1: After reset the register reads 0x17. The enable output is 1, the clock select output is 0, the ratio code is 01 and the peripheral selects are 00.
- R2: Bits 3:2 hold the ratio code: 01 means ×2, 10 means ×3 and 11 means ×4. A write that supplies 00 in this field leaves the previous code in place.
- R3: Only the first write that puts a different legal code into bits 3:2 is accepted after reset. Any later different code is ignored until the next reset. A write that repeats the current code does not use up this one change.
- R4: A write whose ratio change is accepted clears bit 5 on the same clock edge, whatever value the data puts in bit 5.
- R5: Bit 5 selects the system clock, with 0 for the crystal and 1 for the PLL. Output sysClkSel follows bit 5 when the effective enable is 1.
- R6: Bit 1 is the stored PLL enable. A write with bit 1 at 0 also clears bit 5. While the stored enable is 0, a write cannot set bit 5 (even one that sets bit 1 again), and bit 5 reads as 0.
- R7: While haltMode is 1, pllEnOut and sysClkSel are both 0. The stored register bits and the readback are not changed.
- R8: Bits 0 and 4 always read as 1. Writes to them have no effect.
- R9: Bits 7:6 drive perClkSel, reset to 00 and take the written value on each write.
- R10: The register changes only on the rising clock edge at which wrEn is 1. Without a write, every bit holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| haltMode | input | 1 | High in stop or parallel programming mode |
| rdData | output | 8 | Register readback |
| pllEnOut | output | 1 | Effective PLL enable |
| ratioCode | output | 2 | Multiplication ratio code |
| sysClkSel | output | 1 | Clock choice: 0 crystal, 1 PLL |
| perClkSel | output | 2 | Peripheral clock selects |

## Verification
The bench builds the block with its default parameters: the write-once lock switched on, a reset ratio of 01 and a reset enable of 1. With these values the bench can take the lock through its whole life. It checks that a write repeating the current code leaves the one allowed change unused, that the first real change is accepted and then holds, and that a second reset clears the lock. The same values also let the bench check a write of code 00 and a write that sets both the enable and the select while the stored enable is 0.

// File: rtl/pll_clk_ctrl_pkg.sv
package pll_clk_ctrl_pkg;
  localparam int REG_W     = 8;
  localparam int RATIO_W   = 2;
  localparam int PER_W     = 2;
  localparam int FIX0_BIT  = 0;
  localparam int EN_BIT    = 1;
  localparam int RATIO_LSB = 2;
  localparam int FIX4_BIT  = 4;
  localparam int SEL_BIT   = 5;
  localparam int PER_LSB   = 6;

  typedef struct packed {
    logic loadCore;   // write accepted: enable and peripheral bits load
    logic ratioTake;  // ratio field changes on this edge
    logic selTake;    // select bit takes the written value
  } ctlStrobeT;
endpackage

// File: rtl/pll_clk_ctrl_ctl.sv
module pll_clk_ctrl_ctl
  import pll_clk_ctrl_pkg::*;
#(
  parameter bit LOCK_ONCE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic               enQ,
  input  logic [RATIO_W-1:0] ratioQ,
  input  logic               lockedQ,
  output ctlStrobeT          strobe
);
  logic [RATIO_W-1:0] reqRatio;
  logic               legalDiff;
  logic               ratioOk;

  assign reqRatio  = wrData[RATIO_LSB +: RATIO_W];
  assign legalDiff = (reqRatio != '0) && (reqRatio != ratioQ);

  generate
    if (LOCK_ONCE) begin : g_lock
      assign ratioOk = legalDiff && !lockedQ;
    end else begin : g_free
      assign ratioOk = legalDiff;
    end
  endgenerate

  always_comb begin
    strobe.loadCore  = wrEn;
    strobe.ratioTake = wrEn && ratioOk;
    // select may be written only when enable is held both before and after
    strobe.selTake   = wrEn && enQ && wrData[EN_BIT] && !ratioOk;
  end

  // R3: once locked, no further ratio change is requested
  a_r3_no_take_when_locked: assert property (@(posedge clk) disable iff (!rstN)
    (LOCK_ONCE && lockedQ) |-> !strobe.ratioTake);
  // R10: nothing is strobed without a write
  a_r10_no_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strobe == '0));
endmodule

// File: rtl/pll_clk_ctrl_dp.sv
module pll_clk_ctrl_dp
  import pll_clk_ctrl_pkg::*;
#(
  parameter logic [RATIO_W-1:0] RATIO_RST = 2'b01,
  parameter bit                 EN_RST    = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobeT          strobe,
  input  logic [REG_W-1:0]   wrData,
  output logic               enQ,
  output logic [RATIO_W-1:0] ratioQ,
  output logic               lockedQ,
  output logic               selQ,
  output logic [PER_W-1:0]   perQ,
  output logic [REG_W-1:0]   rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= EN_RST;
      ratioQ  <= RATIO_RST;
      lockedQ <= 1'b0;
      selQ    <= 1'b0;
      perQ    <= '0;
    end else if (strobe.loadCore) begin
      enQ  <= wrData[EN_BIT];
      perQ <= wrData[PER_LSB +: PER_W];
      selQ <= strobe.selTake ? wrData[SEL_BIT] : 1'b0;
      if (strobe.ratioTake) begin
        ratioQ  <= wrData[RATIO_LSB +: RATIO_W];
        lockedQ <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData                      = '0;
    rdData[FIX0_BIT]            = 1'b1;
    rdData[FIX4_BIT]            = 1'b1;
    rdData[EN_BIT]              = enQ;
    rdData[RATIO_LSB +: RATIO_W] = ratioQ;
    rdData[SEL_BIT]             = selQ;
    rdData[PER_LSB +: PER_W]    = perQ;
  end

  // R6: select never held while enable is clear
  a_r6_sel_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> !selQ);
  // R4: a ratio change lands with the select cleared
  a_r4_ratio_clears_sel: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ratioQ) |-> !selQ);
  // R2: illegal code 00 is never stored
  a_r2_no_zero_code: assert property (@(posedge clk) disable iff (!rstN)
    ratioQ != '0);
  // R10: state holds without a write
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCore |=> $stable(rdData));
endmodule

// File: rtl/pll_clk_ctrl.sv
module pll_clk_ctrl
  import pll_clk_ctrl_pkg::*;
#(
  parameter bit                 LOCK_ONCE = 1'b1,
  parameter logic [RATIO_W-1:0] RATIO_RST = 2'b01,
  parameter bit                 EN_RST    = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic               haltMode,
  output logic [REG_W-1:0]   rdData,
  output logic               pllEnOut,
  output logic [RATIO_W-1:0] ratioCode,
  output logic               sysClkSel,
  output logic [PER_W-1:0]   perClkSel
);
  ctlStrobeT          strobe;
  logic               enQ;
  logic               lockedQ;
  logic               selQ;
  logic [RATIO_W-1:0] ratioQ;

  pll_clk_ctrl_ctl #(.LOCK_ONCE(LOCK_ONCE)) ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .enQ(enQ), .ratioQ(ratioQ), .lockedQ(lockedQ), .strobe(strobe)
  );

  pll_clk_ctrl_dp #(.RATIO_RST(RATIO_RST), .EN_RST(EN_RST)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .enQ(enQ), .ratioQ(ratioQ), .lockedQ(lockedQ), .selQ(selQ),
    .perQ(perClkSel), .rdData(rdData)
  );

  assign ratioCode = ratioQ;
  assign pllEnOut  = enQ && !haltMode;
  assign sysClkSel = selQ && pllEnOut;

  // R7: halt forces the crystal clock
  a_r7_halt_crystal: assert property (@(posedge clk) disable iff (!rstN)
    haltMode |-> (!sysClkSel && !pllEnOut));
  // R5: PLL clock is chosen only with the PLL running
  a_r5_sel_implies_en: assert property (@(posedge clk) disable iff (!rstN)
    sysClkSel |-> pllEnOut);
  // R8: fixed bits read as one
  a_r8_fixed_ones: assert property (@(posedge clk) disable iff (!rstN)
    rdData[FIX0_BIT] && rdData[FIX4_BIT]);
endmodule

// File: tb/pll_clk_ctrl_tb_top.sv
module pll_clk_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       haltMode = 1'b0;
  logic [7:0] rdData;
  logic       pllEnOut;
  logic [1:0] ratioCode;
  logic       sysClkSel;
  logic [1:0] perClkSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pll_clk_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .haltMode(haltMode), .rdData(rdData), .pllEnOut(pllEnOut),
    .ratioCode(ratioCode), .sysClkSel(sysClkSel), .perClkSel(perClkSel)
  );

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       pe;
    logic       sc;
    logic [1:0] rc;
    logic [1:0] pc;
  } expT;
  expT expQ[$];

  // reference state from the requirements
  logic       mEn;
  logic [1:0] mRat;
  logic       mLock;
  logic       mSel;
  logic [1:0] mPer;

  task automatic modelReset();
    mEn = 1'b1; mRat = 2'b01; mLock = 1'b0; mSel = 1'b0; mPer = 2'b00;
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle per step, pushes the expectation for the next sample
  task automatic step(input logic we, input logic [7:0] d, input logic halt, input string tag);
    expT e;
    logic [1:0] nr;
    logic chg;
    @(negedge clk);
    wrEn = we; wrData = d; haltMode = halt;
    if (we) begin
      nr  = d[3:2];
      chg = (nr != 2'b00) && (nr != mRat) && !mLock;
      if (chg) begin mRat = nr; mLock = 1'b1; end
      mSel = (mEn && d[1] && !chg) ? d[5] : 1'b0;
      mEn  = d[1];
      mPer = d[7:6];
    end
    e.tag = tag;
    e.rd  = {mPer, mSel, 1'b1, mRat, mEn, 1'b1};
    e.pe  = mEn && !halt;
    e.sc  = mSel && mEn && !halt;
    e.rc  = mRat;
    e.pc  = mPer;
    #1 expQ.push_back(e);
  endtask

  // monitor: samples away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        wrEn = 1'b0;
        cmp(e.tag, "rdData", rdData, e.rd);
        cmp(e.tag, "pllEnOut", pllEnOut, e.pe);
        cmp(e.tag, "sysClkSel", sysClkSel, e.sc);
        cmp(e.tag, "ratioCode", ratioCode, e.rc);
        cmp(e.tag, "perClkSel", perClkSel, e.pc);
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    wrEn = 1'b0; haltMode = 1'b0; rstN = 1'b0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    modelReset();
    doReset();
    step(1'b0, 8'h00, 1'b0, "R1 reset state");
    step(1'b1, 8'hA6, 1'b0, "R5 R9 select PLL, per=10");
    step(1'b0, 8'h00, 1'b0, "R10 hold without write");
    step(1'b1, 8'hE2, 1'b0, "R2 code 00 keeps ratio");
    step(1'b1, 8'h26, 1'b0, "R3 same code no lock use");
    step(1'b1, 8'h2E, 1'b0, "R4 ratio x4 clears select");
    step(1'b1, 8'h2A, 1'b0, "R3 locked, x3 ignored");
    step(1'b0, 8'h00, 1'b1, "R7 halt forces crystal");
    step(1'b0, 8'h00, 1'b0, "R7 halt released");
    step(1'b1, 8'h00, 1'b0, "R8 zero write keeps fixed ones");
    step(1'b1, 8'h20, 1'b0, "R6 clear enable clears select");
    step(1'b1, 8'h22, 1'b0, "R6 select blocked while enable 0");
    step(1'b1, 8'h22, 1'b0, "R6 select after enable set");
    step(1'b1, 8'hFF, 1'b1, "R7 R8 halt with all-ones write");
    drain();
    doReset();
    step(1'b0, 8'h00, 1'b0, "R1 second reset state");
    step(1'b1, 8'h0A, 1'b0, "R3 lock cleared by reset, x3");
    step(1'b1, 8'h4E, 1'b0, "R3 R9 x4 ignored, per=01");
    step(1'b1, 8'h2B, 1'b0, "R2 R5 ratio kept, select on");
    drain();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule